// File: doc/BRIEF.md
# Tree Pseudo-LRU Replacement State

This block holds the replacement history of an N-way set-associative cache. It uses a binary-tree approximation of least-recently-used order. Each set owns N−1 history bits. The bits sit in the nodes of a complete binary tree, stored in heap order: node `i` has children `2i+1` and `2i+2`. Each node bit records the branch that was taken most recently below it. The cache control logic around the block owns the tags and the hit detection. It uses this block only to decide which way to evict and to report which way was just used.

The victim query is combinational. Present a set index and `vic_way` shows the way to replace in that set. When `vic_req` is high, the tree of that set is updated at the next clock edge so that the chosen way becomes the most recent. The touch port reports a hit. It updates the tree for the way that hit, using the same update rule. The way count must be a power of two. A one-way cache needs no history, so the block stores no state in that case and always answers way 0.

Top module: `plru_tree_repl`

## Requirements
- R1: After reset, every history bit is 0. A victim query to a set that has been neither victimised nor touched since reset returns way NUM_WAYS−1.
- R2: The victim way is built MSB first. The walk starts at node 0 and, at each of log2(NUM_WAYS) levels, reads node bit f and appends the bit NOT f. It then moves to node 2·i+f+1.
- R3: With `vic_req` high, the set's tree is updated at the next edge for the returned way. An immediately following victim query to the same set returns a different way.
- R4: A touch walks from node 0. At each level it writes way bit b (MSB first) into the node and moves to node 2·i+2−b. A victim query that follows to that set does not return the touched way.
- R5: An update to one set leaves the history of every other set unchanged. Cycles with neither request change nothing.
- R6: A victim request and a touch to the same set in the same cycle are a collision. The victim update is applied and the touch is dropped.
- R7: A victim request and a touch to different sets in the same cycle are both applied.
- R8: NUM_WAYS consecutive victim requests to one set, with no touches in between, return every way exactly once.
- R9: With NUM_WAYS = 1 the block returns way 0 for every query and keeps no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset; clears all history bits |
| vic_req | input | 1 | Commit the victim shown on `vic_way` for `vic_set` |
| vic_set | input | SET_W | Set index for the victim query |
| vic_way | output | WAY_W | Way to replace in `vic_set` (combinational) |
| touch_en | input | 1 | A hit occurred; update the tree for `touch_way` |
| touch_set | input | SET_W | Set index of the hit |
| touch_way | input | WAY_W | Way that hit |

## Verification
The hardest case to reach from the ports is a collision where a dropped touch would actually have changed a later answer. Many touch ways rewrite only bits that the victim update overwrites anyway, so the mistake stays invisible. The bench forces one chosen collision: in a fresh 4-way set, it pairs the victim (way 3) with a touch of way 0. Applying that touch would turn the next victim from 1 into 2. It then runs a long pseudo-random stream in which about half the touches are steered onto the victim's set. This exercises the collision against many tree states in the 4-way and 8-way instances at once.

// File: rtl/plru_pkg.sv
package plru_pkg;

   // Heap child reached while reading a node bit during the victim walk
   function automatic int read_child(int idx, logic f);
      return 2 * idx + int'(f) + 1;
   endfunction

   // Heap child reached while writing a way bit during the update walk
   function automatic int write_child(int idx, logic b);
      return 2 * idx + 2 - int'(b);
   endfunction

   function automatic bit is_pow2(int n);
      return (n > 0) && ((n & (n - 1)) == 0);
   endfunction

endpackage

// File: rtl/plru_victim_walk.sv
module plru_victim_walk #(
   parameter int DEPTH = 3,
   localparam int NODES = (1 << DEPTH) - 1
) (
   input  logic [NODES-1:0] tree,
   output logic [DEPTH-1:0] way
);
   import plru_pkg::*;

   always_comb begin
      int idx;
      idx = 0;
      way = '0;
      for (int lvl = 0; lvl < DEPTH; lvl++) begin
         way[DEPTH-1-lvl] = ~tree[idx];
         idx = read_child(idx, tree[idx]);
      end
   end

endmodule

// File: rtl/plru_update_walk.sv
module plru_update_walk #(
   parameter int DEPTH = 3,
   localparam int NODES = (1 << DEPTH) - 1
) (
   input  logic [DEPTH-1:0] way,
   output logic [NODES-1:0] mask,
   output logic [NODES-1:0] val
);
   import plru_pkg::*;

   always_comb begin
      int idx;
      logic b;
      idx  = 0;
      mask = '0;
      val  = '0;
      for (int lvl = 0; lvl < DEPTH; lvl++) begin
         b         = way[DEPTH-1-lvl];
         mask[idx] = 1'b1;
         val[idx]  = b;
         idx       = write_child(idx, b);
      end
   end

endmodule

// File: rtl/plru_state_array.sv
module plru_state_array #(
   parameter int NUM_SETS = 16,
   parameter int NODES    = 7,
   parameter int SET_W    = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SET_W-1:0] rd_set,
   output logic [NODES-1:0] rd_tree,
   input  logic             wa_en,
   input  logic [SET_W-1:0] wa_set,
   input  logic [NODES-1:0] wa_mask,
   input  logic [NODES-1:0] wa_val,
   input  logic             wb_en,
   input  logic [SET_W-1:0] wb_set,
   input  logic [NODES-1:0] wb_mask,
   input  logic [NODES-1:0] wb_val
);

   logic [NUM_SETS-1:0][NODES-1:0] tree_q;
   logic [NUM_SETS-1:0][NODES-1:0] tree_d;

   always_comb begin
      rd_tree = '0;
      for (int s = 0; s < NUM_SETS; s++) begin
         if (rd_set == SET_W'(s)) rd_tree = tree_q[s];
      end
   end

   // Port A is applied first, port B after it. The caller guarantees that
   // the two ports never name the same set in one cycle.
   always_comb begin
      tree_d = tree_q;
      for (int s = 0; s < NUM_SETS; s++) begin
         if (wa_en && wa_set == SET_W'(s))
            tree_d[s] = (tree_d[s] & ~wa_mask) | (wa_val & wa_mask);
         if (wb_en && wb_set == SET_W'(s))
            tree_d[s] = (tree_d[s] & ~wb_mask) | (wb_val & wb_mask);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) tree_q <= '0;
      else        tree_q <= tree_d;
   end

endmodule

// File: rtl/plru_tree_repl.sv
module plru_tree_repl #(
   parameter int NUM_WAYS = 8,
   parameter int NUM_SETS = 16,
   localparam int WAY_W = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1,
   localparam int SET_W = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             vic_req,
   input  logic [SET_W-1:0] vic_set,
   output logic [WAY_W-1:0] vic_way,
   input  logic             touch_en,
   input  logic [SET_W-1:0] touch_set,
   input  logic [WAY_W-1:0] touch_way
);
   import plru_pkg::*;

   localparam int DEPTH = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 0;
   localparam int NODES = (NUM_WAYS > 1) ? NUM_WAYS - 1 : 1;

   initial begin
      assert (is_pow2(NUM_WAYS))
         else $error("plru_tree_repl: NUM_WAYS must be a power of two");
      assert (NUM_SETS >= 1)
         else $error("plru_tree_repl: NUM_SETS must be at least 1");
   end

   if (NUM_WAYS == 1) begin : g_single
      logic unused_inputs;
      assign unused_inputs = ^{clk, rst_n, vic_req, vic_set,
                               touch_en, touch_set, touch_way};
      assign vic_way = '0;
   end else begin : g_tree
      logic [NODES-1:0] cur_tree;
      logic [NODES-1:0] vic_mask, vic_val;
      logic [NODES-1:0] tch_mask, tch_val;
      logic             collide;
      logic             tch_apply;

      assign collide   = vic_req && touch_en && (vic_set == touch_set);
      assign tch_apply = touch_en && !collide;

      plru_state_array #(
         .NUM_SETS (NUM_SETS),
         .NODES    (NODES),
         .SET_W    (SET_W)
      ) u_state (
         .clk     (clk),
         .rst_n   (rst_n),
         .rd_set  (vic_set),
         .rd_tree (cur_tree),
         .wa_en   (vic_req),
         .wa_set  (vic_set),
         .wa_mask (vic_mask),
         .wa_val  (vic_val),
         .wb_en   (tch_apply),
         .wb_set  (touch_set),
         .wb_mask (tch_mask),
         .wb_val  (tch_val)
      );

      plru_victim_walk #(.DEPTH(DEPTH)) u_pick (
         .tree (cur_tree),
         .way  (vic_way)
      );

      plru_update_walk #(.DEPTH(DEPTH)) u_upd_vic (
         .way  (vic_way),
         .mask (vic_mask),
         .val  (vic_val)
      );

      plru_update_walk #(.DEPTH(DEPTH)) u_upd_tch (
         .way  (touch_way),
         .mask (tch_mask),
         .val  (tch_val)
      );
   end

endmodule

// File: rtl/plru_tree_checker.sv
module plru_tree_checker #(
   parameter int NUM_WAYS = 8,
   parameter int NUM_SETS = 16,
   parameter int WAY_W    = 3,
   parameter int SET_W    = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             vic_req,
   input logic [SET_W-1:0] vic_set,
   input logic [WAY_W-1:0] vic_way,
   input logic             touch_en,
   input logic [SET_W-1:0] touch_set,
   input logic [WAY_W-1:0] touch_way
);

   logic [NUM_SETS-1:0] used_q;
   logic                pv_v, pt_v;
   logic [SET_W-1:0]    pv_set, pt_set;
   logic [WAY_W-1:0]    pv_way, pt_way;
   logic                first_used;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         used_q <= '0;
         pv_v   <= 1'b0;
         pt_v   <= 1'b0;
         pv_set <= '0;
         pt_set <= '0;
         pv_way <= '0;
         pt_way <= '0;
      end else begin
         for (int s = 0; s < NUM_SETS; s++) begin
            if ((vic_req && vic_set == SET_W'(s)) ||
                (touch_en && touch_set == SET_W'(s)))
               used_q[s] <= 1'b1;
         end
         pv_v   <= vic_req;
         pv_set <= vic_set;
         pv_way <= vic_way;
         pt_v   <= touch_en && !(vic_req && vic_set == touch_set);
         pt_set <= touch_set;
         pt_way <= touch_way;
      end
   end

   always_comb begin
      first_used = 1'b0;
      for (int s = 0; s < NUM_SETS; s++) begin
         if (vic_set == SET_W'(s)) first_used = used_q[s];
      end
   end

   assert_fresh_set_top_way_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (vic_req && !first_used) |-> (vic_way == WAY_W'(NUM_WAYS - 1)));

   assert_known_way_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !$isunknown(vic_way));

   assert_victim_moves_on_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ((NUM_WAYS > 1) && pv_v && vic_req && vic_set == pv_set) |-> (vic_way != pv_way));

   assert_touch_protects_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ((NUM_WAYS > 1) && pt_v && vic_req && vic_set == pt_set) |-> (vic_way != pt_way));

endmodule

bind plru_tree_repl plru_tree_checker #(
   .NUM_WAYS (NUM_WAYS),
   .NUM_SETS (NUM_SETS),
   .WAY_W    (WAY_W),
   .SET_W    (SET_W)
) u_plru_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .vic_req   (vic_req),
   .vic_set   (vic_set),
   .vic_way   (vic_way),
   .touch_en  (touch_en),
   .touch_set (touch_set),
   .touch_way (touch_way)
);

// File: tb/test_plru_tree_repl.sv
module test_plru_tree_repl;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic       rst_n;
   logic       vr, te;
   logic [1:0] vs, ts;
   logic [2:0] tw;
   logic [1:0] wa;
   logic [2:0] wb;
   logic [0:0] wc;

   // A: 4 ways x 4 sets, B: 8 ways x 2 sets, C: 1 way x 2 sets
   plru_tree_repl #(.NUM_WAYS(4), .NUM_SETS(4)) i_plru_tree_repl (
      .clk(clk), .rst_n(rst_n), .vic_req(vr), .vic_set(vs), .vic_way(wa),
      .touch_en(te), .touch_set(ts), .touch_way(tw[1:0]));

   plru_tree_repl #(.NUM_WAYS(8), .NUM_SETS(2)) i_plru_tree_repl_w8 (
      .clk(clk), .rst_n(rst_n), .vic_req(vr), .vic_set(vs[0:0]), .vic_way(wb),
      .touch_en(te), .touch_set(ts[0:0]), .touch_way(tw));

   plru_tree_repl #(.NUM_WAYS(1), .NUM_SETS(2)) i_plru_tree_repl_w1 (
      .clk(clk), .rst_n(rst_n), .vic_req(vr), .vic_set(vs[0:0]), .vic_way(wc),
      .touch_en(te), .touch_set(ts[0:0]), .touch_way(tw[0:0]));

   int checks = 0;
   int fails  = 0;
   bit done   = 0;
   logic [6:0] mA [4];
   logic [6:0] mB [2];

   // Reference model written from R2 and R4 (heap-ordered node bits)
   function automatic int pick(logic [6:0] t, int d);
      int n = 0;
      int w = 0;
      for (int l = 0; l < d; l++) begin
         int f;
         f = int'(t[n]);
         w = (w << 1) | (1 - f);
         n = 2 * n + f + 1;
      end
      return w;
   endfunction

   function automatic logic [6:0] mark(logic [6:0] t, int w, int d);
      int n = 0;
      logic [6:0] r = t;
      for (int l = 0; l < d; l++) begin
         int b;
         b = (w >> (d - 1 - l)) & 1;
         r[n] = b[0];
         n = 2 * n + 2 - b;
      end
      return r;
   endfunction

   task automatic chk(string tag, string inst, int s, int got, int exp);
      checks++;
      if (got != exp) begin
         fails++;
         $display("FAIL %s %s set %0d: actual %0d expected %0d", tag, inst, s, got, exp);
      end
   endtask

   task automatic op(bit v, int s, bit t, int tsi, int twi, string tag);
      int pa, pb;
      @(negedge clk);
      vr = v; vs = 2'(s); te = t; ts = 2'(tsi); tw = 3'(twi);
      #2;
      pa = pick(mA[s], 2);
      pb = pick(mB[s % 2], 3);
      chk(tag, "4-way", s, int'(wa), pa);
      chk(tag, "8-way", s % 2, int'(wb), pb);
      chk((tag == "R1") ? "R1" : "R9", "1-way", s % 2, int'(wc), 0);
      if (v) begin
         mA[s]     = mark(mA[s], pa, 2);
         mB[s % 2] = mark(mB[s % 2], pb, 3);
      end
      if (t && !(v && tsi == s))             mA[tsi]     = mark(mA[tsi], twi % 4, 2);
      if (t && !(v && (tsi % 2) == (s % 2))) mB[tsi % 2] = mark(mB[tsi % 2], twi, 3);
   endtask

   initial begin
      #2000000;
      if (!done) begin
         fails++;
         $display("FAIL watchdog R5: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      logic [15:0] lf;
      int seen;
      rst_n = 1'b0; vr = 0; te = 0; vs = 0; ts = 0; tw = 0;
      for (int i = 0; i < 4; i++) mA[i] = '0;
      for (int i = 0; i < 2; i++) mB[i] = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state seen without committing (3 / 7 / 0)
      for (int s = 0; s < 4; s++) op(0, s, 0, 0, 0, "R1");
      // R1: first committed victim in set 0
      op(1, 0, 0, 0, 0, "R1");

      // R6: collision in fresh set 1; touching way 0 would turn next victim 1 into 2
      op(1, 1, 1, 1, 0, "R6");
      op(0, 1, 0, 0, 0, "R6");
      chk("R6", "4-way", 1, int'(wa), 1);

      // R7: victim set 2 with touch set 3 way 1 in the same cycle
      op(1, 2, 1, 3, 1, "R7");
      op(0, 3, 0, 0, 0, "R7");
      op(0, 2, 0, 0, 0, "R7");

      // R5: idle cycles leave everything unchanged
      repeat (3) op(0, 3, 0, 0, 0, "R5");

      // R8: eight consecutive victims in 8-way set 1 cover all ways
      seen = 0;
      for (int i = 0; i < 8; i++) begin
         op(1, 3, 0, 0, 0, "R8");
         seen = seen | (1 << int'(wb));
      end
      chk("R8", "8-way", 1, seen, 255);

      // R8: four consecutive victims in 4-way set 0 cover all ways
      seen = 0;
      for (int i = 0; i < 4; i++) begin
         op(1, 0, 0, 0, 0, "R8");
         seen = seen | (1 << int'(wa));
      end
      chk("R8", "4-way", 0, seen, 15);

      // R4: exhaustive touch of every way in every set, then query that set
      for (int s = 0; s < 4; s++) begin
         for (int w = 0; w < 8; w++) begin
            op(0, 0, 1, s, w, "R4");
            op(1, s, 0, 0, 0, "R4");
            chk("R4", "4-way", s, (int'(wa) != (w % 4)) ? 1 : 0, 1);
         end
      end

      // R3: back-to-back victims in one set never repeat
      for (int i = 0; i < 6; i++) begin
         int prev;
         op(1, 2, 0, 0, 0, "R3");
         prev = int'(wa);
         op(0, 2, 0, 0, 0, "R3");
         chk("R3", "4-way", 2, (int'(wa) != prev) ? 1 : 0, 1);
      end

      // R5/R6/R7: pseudo-random mix, many touches steered onto the victim set
      lf = 16'hACE1;
      for (int i = 0; i < 3000; i++) begin
         int s, tsi;
         lf  = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
         s   = int'(lf[3:2]);
         tsi = lf[6] ? s : int'(lf[5:4]);
         op(lf[0], s, lf[1], tsi, int'(lf[9:7]), "R5");
      end

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule